// File: doc/BRIEF.md
# PAL Line Alternation and Colour Killer

This block keeps the line-by-line phase switch of a PAL chroma decoder in step with the transmitted burst and decides whether colour is shown. A one-bit alternation register flips on every line pulse and picks the +90 or −90 degree reference for the V demodulator. Once per line, a burst-gate strobe delivers the sign of the demodulated burst. An up/down saturating integrator of `LVL_W` bits stands in for the killer capacitor and accumulates that sign.

Positive burst results drive the integrator upward, and colour is enabled once it reaches the on threshold. Colour stays on until the integrator drops below a lower off threshold. Repeated negative results mean the alternation is in the wrong phase. When the integrator falls to the inhibit level, the block withholds exactly one toggle of the alternation register and reloads the integrator to mid-scale. A no-video indication overrides everything: colour is forced off, the integrator is held at mid-scale, and the alternation bit is held at zero.

Top module: `pal_alt_killer`

## Requirements
- R1: After reset, `pal_sw` is 0, `colour_on` is 0 and the integrator sits at mid-scale (`MID_LVL`, 128 by default).
- R2: While `no_video` is low and no reversal is pending, each cycle with `line_pulse` high inverts `pal_sw` on the next clock edge.
- R3: A cycle with `burst_strobe` and `burst_pos` both high raises the integrator by one. The integrator saturates at its all-ones value (255) and does not wrap.
- R4: `colour_on` goes high on the same edge that the integrator reaches `ON_LVL` (192). From mid-scale this takes 64 positive strobes.
- R5: Once on, `colour_on` stays high while the integrator is at or above `OFF_LVL` (160). It drops on the edge at which the integrator goes below `OFF_LVL`.
- R6: A cycle with `burst_strobe` high and `burst_pos` low lowers the integrator by one. If the lowered value would be at or below `INH_LVL` (32), the integrator reloads to mid-scale instead, and the next line pulse leaves `pal_sw` unchanged. Only that one line pulse is suppressed.
- R7: While `no_video` is high, `colour_on` is 0, the integrator is held at mid-scale, `pal_sw` is 0, any pending reversal is cancelled, and strobes and line pulses have no effect.
- R8: `burst_pos` has no effect in cycles where `burst_strobe` is low, and line pulses alone never move the integrator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_pulse | input | 1 | One-cycle line-rate strobe |
| burst_strobe | input | 1 | One-cycle strobe marking a valid burst sign |
| burst_pos | input | 1 | Burst demodulation sign, 1 = positive |
| no_video | input | 1 | High while no video signal is detected |
| pal_sw | output | 1 | Alternation bit selecting the ±90 degree reference |
| colour_on | output | 1 | Colour enable from the killer |

## Verification
The integrator is not visible at the ports, so an error in its value shows up only as a shift in when `colour_on` rises or falls, or in when the alternation register skips a toggle. A miscount near saturation is visible only after a long run of negatives: `colour_on` then falls one or more strobes early or late. A missing or doubled skip shows on the very next line pulse, as a wrong `pal_sw` value. The bench compares both outputs against a reference model after every cycle, so the first divergent edge is reported.

// File: rtl/pal_alt_killer.sv
module pal_alt_killer #(
  parameter int LVL_W   = 8,
  parameter int MID_LVL = 1 << (LVL_W - 1),
  parameter int ON_LVL  = 192,
  parameter int OFF_LVL = 160,
  parameter int INH_LVL = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_pulse,
  input  logic burst_strobe,
  input  logic burst_pos,
  input  logic no_video,
  output logic pal_sw,
  output logic colour_on
);

  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_MID = LVL_W'(MID_LVL);
  localparam logic [LVL_W-1:0] LVL_ON  = LVL_W'(ON_LVL);
  localparam logic [LVL_W-1:0] LVL_OFF = LVL_W'(OFF_LVL);
  localparam logic [LVL_W-1:0] LVL_INH = LVL_W'(INH_LVL);

  logic [LVL_W-1:0] level, level_nxt;
  logic             skip, flip, colour_nxt;

  wire up   = burst_strobe &  burst_pos;
  wire down = burst_strobe & ~burst_pos;
  wire hit_inh = down && (level <= LVL_INH + 1'b1);

  always_comb begin
    level_nxt = level;
    flip      = 1'b0;
    if (up && level != LVL_MAX)
      level_nxt = level + 1'b1;
    else if (hit_inh) begin
      level_nxt = LVL_MID;
      flip      = 1'b1;
    end else if (down)
      level_nxt = level - 1'b1;
  end

  assign colour_nxt = (level_nxt >= LVL_ON)  ? 1'b1 :
                      (level_nxt <  LVL_OFF) ? 1'b0 : colour_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= LVL_MID;
      colour_on <= 1'b0;
      pal_sw    <= 1'b0;
      skip      <= 1'b0;
    end else if (no_video) begin
      level     <= LVL_MID;
      colour_on <= 1'b0;
      pal_sw    <= 1'b0;
      skip      <= 1'b0;
    end else begin
      level     <= level_nxt;
      colour_on <= colour_nxt;
      if (line_pulse && !skip)
        pal_sw <= ~pal_sw;
      if (flip)
        skip <= 1'b1;
      else if (line_pulse)
        skip <= 1'b0;
    end
  end

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse && !skip && !no_video |=> pal_sw != $past(pal_sw));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up && level == LVL_MAX && !no_video |=> level == LVL_MAX);

  p_on_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(colour_on) |-> level >= LVL_ON);

  p_off_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(colour_on) && !$past(no_video) |-> level < LVL_OFF);

  p_skip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skip && line_pulse && !no_video |=> $stable(pal_sw));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_inh && !no_video |=> level == LVL_MID && skip);

  p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_video |=> !colour_on && !pal_sw && level == LVL_MID);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_strobe && !no_video |=> $stable(level));

endmodule

// File: tb/test_pal_alt_killer.sv
module test_pal_alt_killer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_pulse = 1'b0, burst_strobe = 1'b0, burst_pos = 1'b0, no_video = 1'b0;
  logic pal_sw, colour_on;

  pal_alt_killer i_pal_alt_killer (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
    .burst_strobe(burst_strobe), .burst_pos(burst_pos),
    .no_video(no_video), .pal_sw(pal_sw), .colour_on(colour_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic sw; logic con; string req; } exp_t;
  exp_t q[$];

  int applied = 0, fails = 0;
  int m_lvl = 128;
  logic m_sw = 1'b0, m_con = 1'b0, m_skip = 1'b0;
  logic done = 1'b0;

  task automatic step(input logic lp, input logic bs, input logic bp,
                      input logic nv, input string req);
    exp_t e;
    @(negedge clk);
    line_pulse = lp; burst_strobe = bs; burst_pos = bp; no_video = nv;
    if (nv) begin
      m_lvl = 128; m_con = 1'b0; m_sw = 1'b0; m_skip = 1'b0;
    end else begin
      logic set_skip;
      set_skip = 1'b0;
      if (bs && bp) begin
        if (m_lvl < 255) m_lvl++;
      end else if (bs) begin
        if (m_lvl - 1 <= 32) begin m_lvl = 128; set_skip = 1'b1; end
        else m_lvl--;
      end
      if (m_lvl >= 192) m_con = 1'b1;
      else if (m_lvl < 160) m_con = 1'b0;
      if (lp && !m_skip) m_sw = ~m_sw;
      if (set_skip) m_skip = 1'b1;
      else if (lp) m_skip = 1'b0;
    end
    e.sw = m_sw; e.con = m_con; e.req = req;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      applied++;
      if (pal_sw !== e.sw || colour_on !== e.con) begin
        fails++;
        $display("FAIL %s: pal_sw/colour_on = %b/%b, expected %b/%b",
                 e.req, pal_sw, colour_on, e.sw, e.con);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected end of stimulus");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state held while idle
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R1");
    // R2: plain toggling
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R2");
    // R8: sign without strobe, line pulses alone
    for (int i = 0; i < 6; i++) step(i[0], 0, 1, 0, "R8");
    // R4: 64 positive lines reach the on threshold
    for (int i = 0; i < 70; i++) begin
      step(0, 1, 1, 0, "R4");
      step(1, 0, 0, 0, "R2");
    end
    // R3: saturate at the top
    for (int i = 0; i < 90; i++) step(0, 1, 1, 0, "R3");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R8");
    // R5: hysteresis on the way down (95 stay on, 96th turns off)
    for (int i = 0; i < 100; i++) step(0, 1, 0, 0, "R5");
    // R6: continue to inhibit level, reversal and single skip
    for (int i = 0; i < 130; i++) step(0, 1, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R6");
    // R6: strobe coinciding with a line pulse
    for (int i = 0; i < 95; i++) step(0, 1, 0, 0, "R6");
    step(1, 1, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R6");
    // R7: no-video override with a pending skip
    for (int i = 0; i < 96; i++) step(0, 1, 0, 0, "R7");
    for (int i = 0; i < 6; i++) step(i[0], 1, 1, 1, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R7");
    for (int i = 0; i < 64; i++) step(0, 1, 1, 0, "R4");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule